// File: doc/BRIEF.md
# Flash Memory Controller Model

This block models a small on-chip flash and its controller. A memory port serves word reads and programming writes over two regions. The main array is organised as pages, and a separate user-configuration region sits at a fixed byte offset above it. A register port holds a mode register that gates what the memory port and the erase triggers may do. It also holds four trigger registers: two equivalent page-erase registers, a full-array erase and a configuration-region erase. A status register reports when the controller is idle.

Erases are sequenced over the storage one word per clock, and each cleared word becomes all ones. While an erase runs, both ports hold their ready outputs low, so any access is stalled until the erase ends. Page size, page count and configuration-region size are parameters, kept small by default: 16 pages of 16 words, and 16 configuration words.

Top module: `nvm_ctrl`

## Requirements
- R1: After reset, status bit 0 reads 1 and the mode register reads 0. Every word of both regions reads 0xFFFFFFFF.
- R2: The mode register is at register offset 1 in bits [1:0]. Any value 0 to 3 reads back exactly as written, and bits [31:2] read 0.
- R3: In mode 1, a memory-port write stores the word, and a later read returns it. This holds for both regions: the main array at byte addresses 0 to 1023 and the configuration region at byte address 1024 plus 4 times the word index.
- R4: In modes 0, 2 and 3, memory-port writes are ignored and the stored word is unchanged.
- R5: In mode 2, writing a byte address below 1024 to register offset 2 or offset 3 erases that page to 0xFFFFFFFF. The page index is address bits [9:6]. Other pages are unchanged, and an address of 1024 or more is ignored.
- R6: In mode 2, writing a value with bit 0 set to register offset 4 erases the whole main array. The configuration region is unchanged.
- R7: In mode 2, writing a value with bit 0 set to register offset 5 erases the configuration region. The main array is unchanged.
- R8: Erase triggers have no effect in modes 0, 1 and 3. Writes to offsets 4 or 5 with bit 0 clear also have no effect.
- R9: An erase holds the status bit and both ready outputs at 0 for exactly one cycle per cleared word: 16 for a page, 256 for the main array and 16 for the configuration region. After that the status bit reads 1 again.
- R10: A memory access issued during an erase is stalled until the erase ends. It then completes and sees the erased contents.
- R11: A memory write accepted in the same cycle as a mode-register write is gated by the mode held before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | Register write (1) or read (0) |
| reg_addr_i | input | 3 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| reg_ready_o | output | 1 | Register port accepts the request |
| mem_req_i | input | 1 | Memory access request |
| mem_we_i | input | 1 | Memory write (1) or read (0) |
| mem_addr_i | input | 11 | Memory byte address; bit 10 selects the configuration region |
| mem_wdata_i | input | 32 | Memory write data |
| mem_rdata_o | output | 32 | Memory read data |
| mem_ready_o | output | 1 | Memory port accepts the request |

## Verification
The two ports are independent, so a mode-register write and a memory-port write can be accepted on the same clock edge. The bench drives both requests in one cycle twice. The first switches from mode 2 to mode 1 and the write must be dropped. The second switches from mode 1 to mode 0 and the write must land. Each outcome is judged by reading the word back afterwards. A second overlap is an access that arrives while an erase is running: the bench issues a read right after a page-erase trigger and expects the read to return the erased value once the port releases it.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  localparam int unsigned REG_AW = 3;
  localparam int unsigned DW     = 32;

  localparam logic [REG_AW-1:0] OFF_STATUS    = 3'd0;
  localparam logic [REG_AW-1:0] OFF_MODE      = 3'd1;
  localparam logic [REG_AW-1:0] OFF_PG_ERASE0 = 3'd2;
  localparam logic [REG_AW-1:0] OFF_PG_ERASE1 = 3'd3;
  localparam logic [REG_AW-1:0] OFF_ALL_ERASE = 3'd4;
  localparam logic [REG_AW-1:0] OFF_CFG_ERASE = 3'd5;

  typedef enum logic [1:0] {
    MODE_RO  = 2'd0,
    MODE_WEN = 2'd1,
    MODE_EEN = 2'd2,
    MODE_RSV = 2'd3
  } nvm_mode_e;

  typedef enum logic [1:0] {
    ER_NONE = 2'd0,
    ER_PAGE = 2'd1,
    ER_MAIN = 2'd2,
    ER_CFG  = 2'd3
  } erase_kind_e;
endpackage

// File: rtl/nvm_mode_regs.sv
module nvm_mode_regs
  import nvm_pkg::*;
#(
  parameter int unsigned PAGE_WORDS = 16,
  parameter int unsigned PAGES      = 16,
  localparam int unsigned PAGE_AW   = $clog2(PAGE_WORDS),
  localparam int unsigned PG_W      = $clog2(PAGES),
  localparam int unsigned MAIN_AW   = PAGE_AW + PG_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              busy_i,
  output nvm_mode_e         mode_o,
  output erase_kind_e       kind_o,
  output logic [PG_W-1:0]   page_o,
  output logic [DW-1:0]     rdata_o
);
  nvm_mode_e mode_q;
  logic      page_ok;
  logic      unused_wbits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_RO;
    else if (wr_i && addr_i == OFF_MODE) mode_q <= nvm_mode_e'(wdata_i[1:0]);
  end

  assign page_ok      = (wdata_i[DW-1:MAIN_AW] == '0);
  assign page_o       = wdata_i[MAIN_AW-1:PAGE_AW+2];
  assign unused_wbits = ^wdata_i[PAGE_AW+1:2];

  always_comb begin
    kind_o = ER_NONE;
    if (wr_i && mode_q == MODE_EEN) begin
      unique case (addr_i)
        OFF_PG_ERASE0, OFF_PG_ERASE1: if (page_ok) kind_o = ER_PAGE;
        OFF_ALL_ERASE: if (wdata_i[0]) kind_o = ER_MAIN;
        OFF_CFG_ERASE: if (wdata_i[0]) kind_o = ER_CFG;
        default: kind_o = ER_NONE;
      endcase
    end
  end

  always_comb begin
    unique case (addr_i)
      OFF_STATUS: rdata_o = {{(DW-1){1'b0}}, ~busy_i};
      OFF_MODE:   rdata_o = {{(DW-2){1'b0}}, mode_q};
      default:    rdata_o = '0;
    endcase
  end

  assign mode_o = mode_q;

  // R2
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == OFF_MODE) |=> $stable(mode_q))
    else $error("mode changed without a write");
endmodule

// File: rtl/nvm_erase_seq.sv
module nvm_erase_seq
  import nvm_pkg::*;
#(
  parameter int unsigned PAGE_WORDS  = 16,
  parameter int unsigned PAGES       = 16,
  parameter int unsigned CFG_WORDS   = 16,
  localparam int unsigned MAIN_WORDS = PAGE_WORDS * PAGES,
  localparam int unsigned TOT_WORDS  = MAIN_WORDS + CFG_WORDS,
  localparam int unsigned IW         = $clog2(TOT_WORDS),
  localparam int unsigned PAGE_AW    = $clog2(PAGE_WORDS),
  localparam int unsigned PG_W       = $clog2(PAGES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  erase_kind_e     kind_i,
  input  logic [PG_W-1:0] page_i,
  output logic            busy_o,
  output logic [IW-1:0]   clr_idx_o
);
  logic          busy_q;
  logic [IW-1:0] ptr_q, last_q, s_first, s_last;
  logic          start;

  assign start = (kind_i != ER_NONE);

  always_comb begin
    unique case (kind_i)
      ER_PAGE: begin
        s_first = IW'(page_i) << PAGE_AW;
        s_last  = s_first + IW'(PAGE_WORDS - 1);
      end
      ER_MAIN: begin
        s_first = '0;
        s_last  = IW'(MAIN_WORDS - 1);
      end
      ER_CFG: begin
        s_first = IW'(MAIN_WORDS);
        s_last  = IW'(TOT_WORDS - 1);
      end
      default: begin
        s_first = '0;
        s_last  = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
      last_q <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        ptr_q  <= s_first;
        last_q <= s_last;
      end
    end else if (ptr_q == last_q) begin
      busy_q <= 1'b0;
    end else begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  assign busy_o    = busy_q;
  assign clr_idx_o = ptr_q;

  // R10
  no_start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |-> !busy_q)
    else $error("erase started while busy");

  // R9
  one_word_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && ptr_q != last_q |=> busy_q && ptr_q == $past(ptr_q) + 1'b1)
    else $error("erase did not advance one word");

  // R9
  ptr_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> ptr_q <= last_q && last_q < IW'(TOT_WORDS))
    else $error("erase pointer out of range");
endmodule

// File: rtl/nvm_store.sv
module nvm_store
  import nvm_pkg::*;
#(
  parameter int unsigned WORDS = 272,
  localparam int unsigned IW   = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          clr_i,
  input  logic [IW-1:0] clr_idx_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(WORDS); i++) mem_q[i] <= '1;
    end else begin
      if (clr_i) mem_q[clr_idx_i] <= '1;
      if (wr_i)  mem_q[wr_idx_i]  <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];

  // R10
  no_wr_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && clr_i))
    else $error("program write during erase");
endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
  import nvm_pkg::*;
#(
  parameter int unsigned PAGE_WORDS  = 16,
  parameter int unsigned PAGES       = 16,
  parameter int unsigned CFG_WORDS   = 16,
  localparam int unsigned MAIN_WORDS = PAGE_WORDS * PAGES,
  localparam int unsigned TOT_WORDS  = MAIN_WORDS + CFG_WORDS,
  localparam int unsigned IW         = $clog2(TOT_WORDS),
  localparam int unsigned PG_W       = $clog2(PAGES),
  localparam int unsigned MAIN_AW    = $clog2(MAIN_WORDS) + 2,
  localparam int unsigned MEM_AW     = MAIN_AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              reg_ready_o,
  input  logic              mem_req_i,
  input  logic              mem_we_i,
  input  logic [MEM_AW-1:0] mem_addr_i,
  input  logic [DW-1:0]     mem_wdata_i,
  output logic [DW-1:0]     mem_rdata_o,
  output logic              mem_ready_o
);
  nvm_mode_e           mode;
  erase_kind_e         kind;
  logic [PG_W-1:0]     page;
  logic                busy, reg_wr, mem_wr, in_cfg, idx_ok, unused_lsb;
  logic [MAIN_AW-3:0]  word_off;
  logic [IW-1:0]       idx, clr_idx;
  logic [DW-1:0]       rd_word;

  assign reg_ready_o = ~busy;
  assign mem_ready_o = ~busy;
  assign reg_wr      = reg_req_i & reg_we_i & ~busy;

  // Region select on the top address bit; the config region is smaller than its window
  assign in_cfg     = mem_addr_i[MEM_AW-1];
  assign word_off   = mem_addr_i[MAIN_AW-1:2];
  assign unused_lsb = ^mem_addr_i[1:0];
  assign idx_ok     = ~in_cfg | (32'(word_off) < CFG_WORDS);
  assign idx        = in_cfg ? IW'(MAIN_WORDS) + IW'(word_off) : IW'(word_off);
  assign mem_wr     = mem_req_i & mem_we_i & ~busy & idx_ok & (mode == MODE_WEN);
  assign mem_rdata_o = idx_ok ? rd_word : '0;

  nvm_mode_regs #(.PAGE_WORDS(PAGE_WORDS), .PAGES(PAGES)) regs_i (
    .clk_i, .rst_ni,
    .wr_i(reg_wr), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .busy_i(busy),
    .mode_o(mode), .kind_o(kind), .page_o(page), .rdata_o(reg_rdata_o)
  );

  nvm_erase_seq #(.PAGE_WORDS(PAGE_WORDS), .PAGES(PAGES), .CFG_WORDS(CFG_WORDS)) seq_i (
    .clk_i, .rst_ni,
    .kind_i(kind), .page_i(page), .busy_o(busy), .clr_idx_o(clr_idx)
  );

  nvm_store #(.WORDS(TOT_WORDS)) store_i (
    .clk_i, .rst_ni,
    .wr_i(mem_wr), .wr_idx_i(idx), .wr_data_i(mem_wdata_i),
    .clr_i(busy), .clr_idx_i(clr_idx),
    .rd_idx_i(idx), .rd_data_o(rd_word)
  );

  // R8
  erase_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(mode) == MODE_EEN)
    else $error("erase began outside erase mode");
endmodule

// File: tb/nvm_ctrl_tb_top.sv
module nvm_ctrl_tb_top;
  localparam int MAIN = 256;
  localparam int TOT  = 272;
  localparam int MAW  = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_req = 0, reg_we = 0, mem_req = 0, mem_we = 0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, mem_wdata = '0;
  logic [MAW-1:0] mem_addr = '0;
  logic [31:0] reg_rdata, mem_rdata;
  logic reg_ready, mem_ready;

  int vecs = 0, fails = 0;
  logic [31:0] model [TOT];

  always #5 clk = ~clk;

  nvm_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_req_i(reg_req), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .reg_ready_o(reg_ready),
    .mem_req_i(mem_req), .mem_we_i(mem_we), .mem_addr_i(mem_addr),
    .mem_wdata_i(mem_wdata), .mem_rdata_o(mem_rdata), .mem_ready_o(mem_ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [MAW-1:0] addr_of(input int i);
    return (i < MAIN) ? MAW'(i * 4) : MAW'(1024 + (i - MAIN) * 4);
  endfunction

  function automatic logic [31:0] pat(input int i, input int seed);
    return (i * 32'h9E3779B9) ^ (seed * 32'h01000193) ^ 32'h5A5A0000;
  endfunction

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    while (!reg_ready) @(negedge clk);
    @(negedge clk);
    reg_req = 0; reg_we = 0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_req = 1; reg_we = 0; reg_addr = a;
    while (!reg_ready) @(negedge clk);
    #1 d = reg_rdata;
    reg_req = 0;
  endtask

  task automatic mem_wr(input int i, input logic [31:0] d);
    @(negedge clk);
    mem_req = 1; mem_we = 1; mem_addr = addr_of(i); mem_wdata = d;
    while (!mem_ready) @(negedge clk);
    @(negedge clk);
    mem_req = 0; mem_we = 0;
  endtask

  task automatic mem_rd(input int i, output logic [31:0] d);
    @(negedge clk);
    mem_req = 1; mem_we = 0; mem_addr = addr_of(i);
    while (!mem_ready) @(negedge clk);
    #1 d = mem_rdata;
    mem_req = 0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    reg_wr(3'd1, {30'b0, m});
  endtask

  // Trigger write, then count cycles with ready low
  task automatic erase(input logic [2:0] a, input logic [31:0] d, output int n);
    reg_wr(a, d);
    n = 0;
    while (!reg_ready) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    for (int i = 0; i < TOT; i++) begin
      mem_rd(i, d);
      chk(tag, d, model[i]);
    end
  endtask

  task automatic both_wr(input logic [1:0] m, input int i, input logic [31:0] d);
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_addr = 3'd1; reg_wdata = {30'b0, m};
    mem_req = 1; mem_we = 1; mem_addr = addr_of(i); mem_wdata = d;
    @(negedge clk);
    reg_req = 0; reg_we = 0; mem_req = 0; mem_we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1
    for (int i = 0; i < TOT; i++) model[i] = '1;
    reg_rd(3'd0, d); chk("R1 status", d & 32'h1, 32'h1);
    reg_rd(3'd1, d); chk("R1 mode", d, 32'h0);
    check_all("R1 array");

    // R2
    for (int m = 0; m < 4; m++) begin
      reg_wr(3'd1, 32'hFFFF_FFF0 | 32'(m));
      reg_rd(3'd1, d); chk("R2 mode readback", d, 32'(m));
    end

    // R4: mode 3, 0 and (later) 2 drop writes
    mem_wr(5, 32'h1234_5678);   mem_rd(5, d);   chk("R4 mode3", d, model[5]);
    set_mode(2'd0);
    mem_wr(260, 32'hCAFE_0001); mem_rd(260, d); chk("R4 mode0", d, model[260]);

    // R8: triggers in mode 0 and 3
    erase(3'd4, 32'h1, n); chk("R8 mode0 no busy", 32'(n), 32'd0);
    set_mode(2'd3);
    erase(3'd5, 32'h1, n); chk("R8 mode3 no busy", 32'(n), 32'd0);

    // R3: fill both regions
    set_mode(2'd1);
    for (int i = 0; i < TOT; i++) begin
      model[i] = pat(i, 1);
      mem_wr(i, model[i]);
    end
    check_all("R3 fill");

    // R8: triggers in mode 1
    erase(3'd4, 32'h1, n);   chk("R8 mode1 all", 32'(n), 32'd0);
    erase(3'd2, 32'd128, n); chk("R8 mode1 page", 32'(n), 32'd0);
    check_all("R8 contents");

    set_mode(2'd2);
    // R4: mode 2
    mem_wr(7, 32'h0);  mem_rd(7, d); chk("R4 mode2", d, model[7]);
    // R8: bit 0 clear
    erase(3'd4, 32'h2, n); chk("R8 bit0 clear", 32'(n), 32'd0);

    // R5 / R9: page erases
    erase(3'd2, 32'd192, n); chk("R9 page cycles", 32'(n), 32'd16);
    for (int i = 48; i < 64; i++) model[i] = '1;
    erase(3'd3, 32'd964, n); chk("R9 page cycles B", 32'(n), 32'd16);
    for (int i = 240; i < 256; i++) model[i] = '1;
    erase(3'd2, 32'd0, n);   chk("R9 page0 cycles", 32'(n), 32'd16);
    for (int i = 0; i < 16; i++) model[i] = '1;
    erase(3'd2, 32'd1024, n); chk("R5 out of range", 32'(n), 32'd0);
    reg_rd(3'd0, d); chk("R9 status idle", d & 32'h1, 32'h1);
    check_all("R5 pages");

    // R10: read issued during erase is stalled, sees erased word
    reg_wr(3'd3, 32'd320);
    chk("R10 busy after trigger", {31'b0, mem_ready}, 32'h0);
    mem_rd(83, d);
    for (int i = 80; i < 96; i++) model[i] = '1;
    chk("R10 stalled read", d, 32'hFFFF_FFFF);

    // R7
    erase(3'd5, 32'h1, n); chk("R9 cfg cycles", 32'(n), 32'd16);
    for (int i = MAIN; i < TOT; i++) model[i] = '1;
    check_all("R7 cfg erase");

    // R6
    set_mode(2'd1);
    for (int i = MAIN; i < TOT; i++) begin
      model[i] = pat(i, 2);
      mem_wr(i, model[i]);
    end
    set_mode(2'd2);
    erase(3'd4, 32'h1, n); chk("R9 all cycles", 32'(n), 32'd256);
    for (int i = 0; i < MAIN; i++) model[i] = '1;
    check_all("R6 erase all");

    // R11: same-cycle mode write and memory write
    both_wr(2'd1, 9, 32'hDEAD_0009);
    mem_rd(9, d); chk("R11 old mode 2 drops", d, model[9]);
    both_wr(2'd0, 10, 32'hBEEF_000A);
    model[10] = 32'hBEEF_000A;
    mem_rd(10, d); chk("R11 old mode 1 keeps", d, model[10]);
    reg_rd(3'd1, d); chk("R11 mode now 0", d, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule